// File: doc/BRIEF.md
# Firmware Record Stream Loader

This block copies a firmware image, arriving as a byte stream, into an on-chip program RAM. The image is a chain of records. Each record holds a little-endian 16-bit load address, then a little-endian 16-bit byte count, then that many payload bytes. The next record starts straight after the last payload byte. The loader walks the headers and sets its RAM address pointer from each one. It writes every payload byte through a single-byte write port, and the address steps up by one after each byte.

A `start` pulse begins a load. `start` raises `cpu_hold`, which keeps the processor that runs from the RAM in reset. When the final byte of a well-formed image has been accepted, the loader drops `cpu_hold`. It then polls the processor's reset-status input until it reads clear. If the processor leaves reset, `done` pulses. If it stays in reset for `TIMEOUT_CYC` cycles, `timeout_err` pulses. If the stream ends part-way through a header or a payload, `frame_err` pulses and the processor stays held.

The controller is a four-state machine:

| State | Meaning |
|-------|---------|
| IDLE | Waiting for `start` |
| HDR | Collecting the four header bytes |
| DATA | Writing payload bytes |
| RELEASE | Polling `cpu_in_reset` |

The transitions are:

| From | To | Condition |
|------|----|-----------|
| IDLE | HDR | `start` |
| HDR | DATA | Fourth header byte gives a non-zero count, no last flag |
| HDR | HDR | Zero count, no last flag |
| HDR | RELEASE | Zero count with the last flag |
| HDR | IDLE | Last flag on header bytes 0 to 2, or a non-zero count with the last flag (`frame_err`) |
| DATA | HDR | Final payload byte, no last flag |
| DATA | RELEASE | Final payload byte with the last flag |
| DATA | IDLE | Last flag on any earlier payload byte (`frame_err`) |
| RELEASE | IDLE | Status reads clear (`done`) |
| RELEASE | IDLE | `TIMEOUT_CYC` cycles pass with the status still set (`timeout_err`) |

Top module: `fw_image_loader`

## Requirements
- R1: Header byte 0 is the low byte and byte 1 the high byte of the load address. Bytes 2 and 3 are the low and high bytes of the count. The first payload byte is written at that address.
- R2: Payload bytes are written in stream order. Each write uses the previous write's address plus one, and 0xFFFF is followed by 0x0000.
- R3: After `count` payload bytes the next accepted byte is header byte 0 of a new record. A record with count 0 writes nothing.
- R4: `s_ready` is high only in HDR and DATA. At most one of `done`, `frame_err` and `timeout_err` is high in any cycle.
- R5: `cpu_hold` rises on the edge that takes `start` in IDLE. It stays high through the load and falls on the edge that accepts the final byte of a well-formed image.
- R6: A last flag on header bytes 0 to 2, or on a payload byte that is not the record's final one, gives a one-cycle `frame_err` and a return to IDLE with `cpu_hold` still high. A payload byte that carries such a flag is still written.
- R7: In RELEASE, the first cycle in which `cpu_in_reset` reads 0 gives a one-cycle `done` on the following edge.
- R8: If `cpu_in_reset` stays 1 for `TIMEOUT_CYC` cycles in RELEASE, `timeout_err` pulses for one cycle on the last of those edges and the block returns to IDLE.
- R9: `start` has no effect outside IDLE.
- R10: `ram_we` is high for the one cycle after each accepted payload byte, with `ram_addr` and `ram_wdata` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (IDLE only) |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of the image |
| s_ready | output | 1 | Loader accepts a byte |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 16 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| cpu_hold | output | 1 | Holds the processor in reset |
| cpu_in_reset | input | 1 | Processor reset status, 1 = still in reset |
| done | output | 1 | One-cycle pulse, load and release complete |
| frame_err | output | 1 | One-cycle pulse, stream ended mid-record |
| timeout_err | output | 1 | One-cycle pulse, processor did not leave reset |

## Verification
Each result has a fixed latency:

- A RAM write appears in the cycle after the edge that accepts its payload byte.
- `cpu_hold` falls, and `frame_err` rises, in the cycle after the edge that accepts the closing byte.
- `done` follows one cycle after `cpu_in_reset` is first seen clear.
- `timeout_err` appears exactly `TIMEOUT_CYC` cycles after `cpu_hold` falls.

The bench drives and samples on the falling edge. It pops expected writes from a queue as each strobe appears. It checks the hold and error levels at the falling edge right after the closing byte. It counts falling edges from the release to the timeout pulse and compares the count with the parameter.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 16;
    localparam int HDR_BYTES = (ADDR_W + CNT_W) / BYTE_W;
    localparam int IDX_W = $clog2(HDR_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_RELEASE
    } fwl_state_e;
endpackage

// File: rtl/fwl_regs.sv
module fwl_regs
    import fwl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_addr_lo,
    input  logic              ld_addr_hi,
    input  logic              ld_cnt_lo,
    input  logic              ld_cnt_hi,
    input  logic              wr_beat,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] cnt_lo,
    output logic [CNT_W-1:0]  cnt_rem,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [BYTE_W-1:0] ram_wdata
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            cnt_lo    <= '0;
            cnt_rem   <= '0;
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we <= wr_beat;
            if (ld_addr_lo) addr_q[BYTE_W-1:0]      <= din;
            if (ld_addr_hi) addr_q[ADDR_W-1:BYTE_W] <= din;
            if (ld_cnt_lo)  cnt_lo                  <= din;
            if (ld_cnt_hi)  cnt_rem                 <= {din, cnt_lo};
            if (wr_beat) begin
                ram_addr  <= addr_q;
                ram_wdata <= din;
                addr_q    <= addr_q + ADDR_W'(1);
                cnt_rem   <= cnt_rem - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/fwl_timer.sv
module fwl_timer #(
    parameter int unsigned TIMEOUT_CYC = 750_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_CYC - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (!run)    cnt_q <= '0;
        else if (!expired) cnt_q <= cnt_q + TW'(1);
    end

    assign expired = run && (cnt_q == LIMIT);
endmodule

// File: rtl/fwl_ctrl.sv
module fwl_ctrl
    import fwl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              s_valid,
    input  logic              s_last,
    input  logic [BYTE_W-1:0] s_data,
    input  logic [BYTE_W-1:0] cnt_lo,
    input  logic [CNT_W-1:0]  cnt_rem,
    input  logic              cpu_in_reset,
    input  logic              tmr_expired,
    output logic              s_ready,
    output logic              ld_addr_lo,
    output logic              ld_addr_hi,
    output logic              ld_cnt_lo,
    output logic              ld_cnt_hi,
    output logic              wr_beat,
    output logic              tmr_run,
    output logic              cpu_hold,
    output logic              done,
    output logic              frame_err,
    output logic              timeout_err
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_BYTES - 1);

    fwl_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             beat, go, image_ok, bad, fin, late;

    assign s_ready = (state_q == ST_HDR) || (state_q == ST_DATA);
    assign beat    = s_valid && s_ready;

    always_comb begin
        state_d    = state_q;
        idx_d      = idx_q;
        ld_addr_lo = 1'b0;
        ld_addr_hi = 1'b0;
        ld_cnt_lo  = 1'b0;
        ld_cnt_hi  = 1'b0;
        wr_beat    = 1'b0;
        tmr_run    = 1'b0;
        go         = 1'b0;
        image_ok   = 1'b0;
        bad        = 1'b0;
        fin        = 1'b0;
        late       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_HDR;
                    idx_d   = '0;
                    go      = 1'b1;
                end
            end
            ST_HDR: begin
                if (beat) begin
                    ld_addr_lo = (idx_q == IDX_W'(0));
                    ld_addr_hi = (idx_q == IDX_W'(1));
                    ld_cnt_lo  = (idx_q == IDX_W'(2));
                    ld_cnt_hi  = (idx_q == IDX_LAST);
                    if (idx_q == IDX_LAST) begin
                        idx_d = '0;
                        if ({s_data, cnt_lo} == '0) begin
                            if (s_last) begin
                                state_d  = ST_RELEASE;
                                image_ok = 1'b1;
                            end
                        end else if (s_last) begin
                            state_d = ST_IDLE;
                            bad     = 1'b1;
                        end else begin
                            state_d = ST_DATA;
                        end
                    end else if (s_last) begin
                        state_d = ST_IDLE;
                        bad     = 1'b1;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            ST_DATA: begin
                if (beat) begin
                    wr_beat = 1'b1;
                    if (cnt_rem == CNT_W'(1)) begin
                        state_d  = s_last ? ST_RELEASE : ST_HDR;
                        image_ok = s_last;
                    end else if (s_last) begin
                        state_d = ST_IDLE;
                        bad     = 1'b1;
                    end
                end
            end
            ST_RELEASE: begin
                tmr_run = 1'b1;
                if (!cpu_in_reset) begin
                    state_d = ST_IDLE;
                    fin     = 1'b1;
                end else if (tmr_expired) begin
                    state_d = ST_IDLE;
                    late    = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_hold    <= 1'b0;
            done        <= 1'b0;
            frame_err   <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            if (go)            cpu_hold <= 1'b1;
            else if (image_ok) cpu_hold <= 1'b0;
            done        <= fin;
            frame_err   <= bad;
            timeout_err <= late;
        end
    end
endmodule

// File: rtl/fw_image_loader.sv
module fw_image_loader
    import fwl_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 750_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [BYTE_W-1:0] ram_wdata,
    output logic              cpu_hold,
    input  logic              cpu_in_reset,
    output logic              done,
    output logic              frame_err,
    output logic              timeout_err
);
    logic              ld_addr_lo, ld_addr_hi, ld_cnt_lo, ld_cnt_hi;
    logic              wr_beat, tmr_run, tmr_expired;
    logic [BYTE_W-1:0] cnt_lo;
    logic [CNT_W-1:0]  cnt_rem;

    fwl_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .s_valid(s_valid),
        .s_last(s_last), .s_data(s_data), .cnt_lo(cnt_lo), .cnt_rem(cnt_rem),
        .cpu_in_reset(cpu_in_reset), .tmr_expired(tmr_expired),
        .s_ready(s_ready), .ld_addr_lo(ld_addr_lo), .ld_addr_hi(ld_addr_hi),
        .ld_cnt_lo(ld_cnt_lo), .ld_cnt_hi(ld_cnt_hi), .wr_beat(wr_beat),
        .tmr_run(tmr_run), .cpu_hold(cpu_hold), .done(done),
        .frame_err(frame_err), .timeout_err(timeout_err)
    );

    fwl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .ld_addr_lo(ld_addr_lo),
        .ld_addr_hi(ld_addr_hi), .ld_cnt_lo(ld_cnt_lo), .ld_cnt_hi(ld_cnt_hi),
        .wr_beat(wr_beat), .din(s_data), .cnt_lo(cnt_lo), .cnt_rem(cnt_rem),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    fwl_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .expired(tmr_expired)
    );
endmodule

// File: rtl/fwl_checker.sv
module fwl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        s_valid,
    input logic        s_ready,
    input logic        ram_we,
    input logic [15:0] ram_addr,
    input logic        cpu_hold,
    input logic        done,
    input logic        frame_err,
    input logic        timeout_err
);
    // R10
    wr_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(s_valid && s_ready));
    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && $past(ram_we)) |-> (ram_addr == 16'($past(ram_addr) + 16'd1)));
    // R5
    hold_during_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> cpu_hold);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cpu_hold);
    // R6
    err_keeps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> cpu_hold);
    // R4
    outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, frame_err, timeout_err}));
    // R8
    tout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> !timeout_err);
endmodule

bind fw_image_loader fwl_checker u_fwl_checker (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .ram_we(ram_we), .ram_addr(ram_addr), .cpu_hold(cpu_hold), .done(done),
    .frame_err(frame_err), .timeout_err(timeout_err)
);

// File: tb/tb_fw_image_loader.sv
module tb_fw_image_loader;
    localparam int TOUT = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, s_valid = 1'b0, s_last = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic s_ready, ram_we, cpu_hold, cpu_in_reset, done, frame_err, timeout_err;
    logic [15:0] ram_addr;
    logic [7:0] ram_wdata;
    logic stuck = 1'b0;
    logic [2:0] cpu_sr;

    int checks = 0, fails = 0, hold_bad = 0;
    logic [7:0]  img[$];
    logic [23:0] expw[$];

    always #2 clk = ~clk;

    fw_image_loader #(.TIMEOUT_CYC(TOUT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .s_valid(s_valid),
        .s_data(s_data), .s_last(s_last), .s_ready(s_ready), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .cpu_hold(cpu_hold),
        .cpu_in_reset(cpu_in_reset), .done(done), .frame_err(frame_err),
        .timeout_err(timeout_err)
    );

    // processor model: leaves reset three cycles after hold drops
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cpu_sr <= '0;
        else        cpu_sr <= {cpu_sr[1:0], cpu_hold};
    end
    assign cpu_in_reset = stuck | cpu_hold | cpu_sr[2];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R1 R2 R10: every write strobe must match the next expected pair
    always @(negedge clk) begin
        if (rst_n && ram_we) begin
            if (expw.size() == 0) begin
                chk(1'b0, "R3", "unexpected write", {ram_addr, ram_wdata}, 0);
            end else begin
                logic [23:0] e;
                e = expw.pop_front();
                chk({ram_addr, ram_wdata} == e, "R1/R2", "write addr,data",
                    {ram_addr, ram_wdata}, e);
            end
        end
    end

    function automatic logic [7:0] rbyte();
        return 8'($urandom_range(0, 255));
    endfunction

    task automatic add_hdr(input logic [15:0] a, input logic [15:0] n);
        img.push_back(a[7:0]); img.push_back(a[15:8]);
        img.push_back(n[7:0]); img.push_back(n[15:8]);
    endtask

    task automatic add_rec(input logic [15:0] a, input int n);
        add_hdr(a, 16'(n));
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = rbyte();
            img.push_back(d);
            expw.push_back({16'(a + 16'(k)), d});
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_image(input int gap_max, input bit poke);
        hold_bad = 0;
        for (int i = 0; i < img.size(); i++) begin
            bit acc;
            int g;
            g = (gap_max > 0) ? $urandom_range(0, gap_max) : 0;
            repeat (g) @(negedge clk);
            s_valid = 1'b1;
            s_data  = img[i];
            s_last  = (i == img.size() - 1);
            start   = poke && (i == 2);
            acc = 1'b0;
            while (!acc) begin
                if (!cpu_hold) hold_bad++;
                acc = s_ready;
                @(negedge clk);
            end
            s_valid = 1'b0;
            s_last  = 1'b0;
            start   = 1'b0;
        end
    endtask

    // kind: 1 done, 2 frame_err, 3 timeout_err
    task automatic wait_outcome(output int kind, output int cyc);
        kind = 0;
        cyc  = 0;
        while (kind == 0 && cyc < 3000) begin
            if (done)             kind = 1;
            else if (frame_err)   kind = 2;
            else if (timeout_err) kind = 3;
            else begin
                @(negedge clk);
                cyc++;
            end
        end
        @(negedge clk);
        chk(!(done || frame_err || timeout_err), "R7", "pulse width one cycle",
            {done, frame_err, timeout_err}, 0);
    endtask

    task automatic run_good(input int gap_max, input bit poke, input string tag);
        int kind, cyc;
        pulse_start();
        send_image(gap_max, poke);
        chk(hold_bad == 0, "R5", {tag, " hold during load"}, hold_bad, 0);
        chk(cpu_hold == 1'b0, "R5", {tag, " hold released after last byte"}, cpu_hold, 0);
        chk(s_ready == 1'b0, "R4", {tag, " ready low after image"}, s_ready, 0);
        wait_outcome(kind, cyc);
        chk(kind == 1, "R7", {tag, " done outcome"}, kind, 1);
        chk(expw.size() == 0, "R3", {tag, " all writes seen"}, expw.size(), 0);
        img.delete();
        expw.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WD", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int kind, cyc;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(s_ready == 0 && cpu_hold == 0 && ram_we == 0 && done == 0,
            "R4", "reset state", {s_ready, cpu_hold, ram_we, done}, 0);

        // R1 R3: two records, zero-count records between and at the end
        add_rec(16'h1234, 3);
        add_rec(16'h0100, 0);
        add_rec(16'hA000, 2);
        add_rec(16'h0042, 0);
        run_good(0, 1'b0, "R1 directed");

        // R2: address wraps past 0xFFFF
        add_rec(16'hFFFD, 5);
        run_good(2, 1'b0, "R2 wrap");

        // R3: image made only of a zero-count record
        add_rec(16'h5555, 0);
        run_good(0, 1'b0, "R3 zero only");

        // R9: start raised mid-stream is ignored
        add_rec(16'h0300, 4);
        add_rec(16'h0800, 3);
        run_good(1, 1'b1, "R9 start ignored");

        // random images
        for (int it = 0; it < 20; it++) begin
            int nrec;
            nrec = $urandom_range(1, 4);
            for (int r = 0; r < nrec; r++) begin
                logic [15:0] a;
                a = ($urandom_range(0, 5) == 0) ? 16'hFFFE : 16'($urandom_range(0, 65535));
                add_rec(a, $urandom_range(0, 6));
            end
            run_good(3, 1'b0, "R2 random");
        end

        // R6: last flag on header byte 1
        img.push_back(8'h10); img.push_back(8'h20);
        pulse_start();
        send_image(0, 1'b0);
        chk(frame_err == 1'b1, "R6", "frame_err mid header", frame_err, 1);
        chk(cpu_hold == 1'b1, "R6", "hold kept after header error", cpu_hold, 1);
        wait_outcome(kind, cyc);
        chk(expw.size() == 0, "R6", "no write on header error", expw.size(), 0);
        img.delete();

        // R6: last flag on third of five payload bytes
        add_hdr(16'h0700, 16'd5);
        for (int k = 0; k < 3; k++) begin
            logic [7:0] d;
            d = rbyte();
            img.push_back(d);
            expw.push_back({16'(16'h0700 + 16'(k)), d});
        end
        pulse_start();
        send_image(1, 1'b0);
        chk(frame_err == 1'b1, "R6", "frame_err mid payload", frame_err, 1);
        chk(cpu_hold == 1'b1, "R6", "hold kept after payload error", cpu_hold, 1);
        wait_outcome(kind, cyc);
        chk(expw.size() == 0, "R6", "early-last byte still written", expw.size(), 0);
        chk(s_ready == 1'b0, "R6", "back in idle", s_ready, 0);
        img.delete();
        expw.delete();

        // R8: processor never leaves reset
        stuck = 1'b1;
        add_rec(16'h0020, 2);
        pulse_start();
        send_image(0, 1'b0);
        wait_outcome(kind, cyc);
        chk(kind == 3, "R8", "timeout outcome", kind, 3);
        chk(cyc == TOUT, "R8", "timeout cycle count", cyc, TOUT);
        img.delete();
        expw.delete();
        stuck = 1'b0;
        repeat (2) @(negedge clk);

        // R7: recovery load after the timeout completes normally
        add_rec(16'hBEEF, 3);
        run_good(0, 1'b0, "R7 after timeout");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule